// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter

This block reduces the sample rate of a stream of signed multi-bit samples by a factor of two with a linear-phase half-band low-pass FIR. Samples arrive with a one-cycle `in_valid` strobe. Every second accepted sample starts the computation of one output, and the output appears as a one-cycle `out_valid` pulse with the result on `out_data`. One shared multiply-accumulate unit computes each output.

Two properties of a half-band filter keep the cycle count low. Every tap at an even, non-zero distance from the center has a weight of zero, so the sequencer never visits those taps. The remaining taps are mirror images of each other around the center. Each mirrored pair of samples is therefore added before the multiply, and a pair costs one cycle. The center weight is exactly one half, and it enters the accumulator as a shifted copy of the sample, so it takes no multiply cycle. With `NUM_TAPS` distinct non-zero side coefficients, the filter spans `4*NUM_TAPS-1` samples. Each output takes `NUM_TAPS` multiply cycles, plus one load cycle and one output cycle.

The coefficients come in through the packed parameter `COEF_LIST`. Entry k sits at bits `[k*COEF_W +: COEF_W]` and is the weight at distance 2k+1 from the center. Each entry is a signed fraction with `COEF_W-1` fraction bits. The block does not design coefficients.

Top module: `hb_decim2`

## Requirements
- R1: After reset, the 2nd, 4th, 6th, … accepted samples (a sample is accepted on a rising edge where `in_valid` is 1) each produce exactly one output, and no other sample produces one.
- R2: `out_valid` is high for exactly one cycle. It rises `NUM_TAPS+2` rising edges after the edge that accepted the triggering sample, and `out_data` carries the result in that cycle.
- R3: Index the samples at the triggering edge with 0 as the newest and 4*NUM_TAPS-2 as the oldest. The center is index 2*NUM_TAPS-1. The output weighs the center sample by exactly 1/2 and the samples at center±(2k+1) by coefficient k. Every other position has zero weight: a sample that reaches only those positions leaves the output at zero.
- R4: The two samples at center-(2k+1) and center+(2k+1) carry the same weight, so a single impulse gives an output sequence that reads the same forwards and backwards.
- R5: The exact weighted sum, scaled by 2^(COEF_W-1), is rounded to an integer by adding one half and taking the floor. A center-only value of 3 gives 2, and -3 gives -1.
- R6: A result above 2^(DATA_W-1)-1 is output as that value. A result below -2^(DATA_W-1) is output as that value.
- R7: A sample accepted while an output is being computed does not change that output. Triggering samples must be at least `NUM_TAPS+2` cycles apart, so a spacing of `(NUM_TAPS+2)/2` cycles between samples is allowed.
- R8: Synchronous active-high reset clears `out_valid` and `out_data` to 0 and the sample history to zeros. The first output after reset comes from the 2nd sample accepted after reset.
- R9: `in_data` is ignored while `in_valid` is 0. No output is produced, and later outputs show no trace of those values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_data | output | DATA_W | Decimated output, rounded and saturated |

## Verification
A wrong pointer into the sample history, or a correction missed after a sample arrives during a computation, shows up as a wrong `out_data` on the very next pulse. Impulses placed at odd and even history positions expose a weight assigned to the wrong tap or a lost mirror pair within one decimated period. A sequencer that loses the input phase or stalls shows at once as a pulse on the wrong sample or `NUM_TAPS+2` cycles off. Rounding and saturation errors show directly on a single center-only output and on an output driven to either rail.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Sequencer states of the shared multiply-accumulate unit
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_MAC  = 2'd2,
        ST_OUT  = 2'd3
    } hb_state_e;

    // Per-cycle datapath commands
    typedef struct packed {
        logic load;   // seed accumulator with the half-weighted center sample
        logic mac;    // add one pre-added mirrored pair times its coefficient
        logic emit;   // round, saturate and present the result
    } hb_ctl_t;

    // History index of the sample on the newer side of pair k (0 = newest)
    function automatic int inner_tap(int k, int n);
        return 2 * n - 2 - 2 * k;
    endfunction

    // History index of the sample on the older side of pair k
    function automatic int outer_tap(int k, int n);
        return 2 * n + 2 * k;
    endfunction

    // Accumulator width: pre-add bit, product, growth over n pairs, plus center term
    function automatic int acc_width(int dw, int cw, int n);
        return dw + cw + $clog2(n) + 2;
    endfunction

endpackage

// File: rtl/hb_sequencer.sv
module hb_sequencer
    import hb_pkg::*;
#(
    parameter int NUM_TAPS = 4,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output hb_ctl_t          ctl,
    output logic [IDX_W-1:0] tap_idx,
    output logic             adj,
    output logic             phase,
    output hb_state_e        state
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);

    logic trig;
    assign trig = in_valid & phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= 1'b0;
            tap_idx <= '0;
            adj     <= 1'b0;
        end else begin
            if (in_valid) begin
                phase <= ~phase;
            end
            if (trig) begin
                // the sample accepted on this edge closes the window
                state   <= ST_LOAD;
                tap_idx <= '0;
                adj     <= 1'b0;
            end else begin
                // a later sample shifts the history by one place
                if (in_valid) begin
                    adj <= 1'b1;
                end
                case (state)
                    ST_LOAD: state <= ST_MAC;
                    ST_MAC: begin
                        if (tap_idx == LAST_IDX) begin
                            state <= ST_OUT;
                        end else begin
                            tap_idx <= tap_idx + 1'b1;
                        end
                    end
                    ST_OUT:  state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        ctl      = '0;
        ctl.load = (state == ST_LOAD);
        ctl.mac  = (state == ST_MAC);
        ctl.emit = (state == ST_OUT);
    end

endmodule

// File: rtl/hb_history.sv
module hb_history
    import hb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_TAPS = 4,
    parameter int IDX_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic [IDX_W-1:0]         tap_idx,
    input  logic                     adj,
    output logic signed [DATA_W-1:0] near_s,
    output logic signed [DATA_W-1:0] far_s,
    output logic signed [DATA_W-1:0] ctr_s,
    output logic signed [DATA_W-1:0] newest
);

    // one spare place keeps the oldest sample after one extra shift
    localparam int DEPTH  = 4 * NUM_TAPS;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CENTER = 2 * NUM_TAPS - 1;
    localparam int INNER0 = inner_tap(0, NUM_TAPS);
    localparam int OUTER0 = outer_tap(0, NUM_TAPS);

    logic signed [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[g] <= '0;
                end else if (in_valid) begin
                    mem[g] <= in_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[g] <= '0;
                end else if (in_valid) begin
                    mem[g] <= mem[g-1];
                end
            end
        end
    end

    logic [PTR_W-1:0] step;
    logic [PTR_W-1:0] near_ptr;
    logic [PTR_W-1:0] far_ptr;
    logic [PTR_W-1:0] ctr_ptr;

    always_comb begin
        step     = PTR_W'({tap_idx, 1'b0});
        near_ptr = PTR_W'(INNER0) - step + PTR_W'(adj);
        far_ptr  = PTR_W'(OUTER0) + step + PTR_W'(adj);
        ctr_ptr  = PTR_W'(CENTER) + PTR_W'(adj);
    end

    assign near_s = mem[near_ptr];
    assign far_s  = mem[far_ptr];
    assign ctr_s  = mem[ctr_ptr];
    assign newest = mem[0];

endmodule

// File: rtl/hb_mac.sv
module hb_mac
    import hb_pkg::*;
#(
    parameter int                          DATA_W    = 16,
    parameter int                          COEF_W    = 18,
    parameter int                          NUM_TAPS  = 4,
    parameter int                          IDX_W     = 2,
    parameter logic [NUM_TAPS*COEF_W-1:0]  COEF_LIST = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  hb_ctl_t                  ctl,
    input  logic [IDX_W-1:0]         tap_idx,
    input  logic signed [DATA_W-1:0] near_s,
    input  logic signed [DATA_W-1:0] far_s,
    input  logic signed [DATA_W-1:0] ctr_s,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int FRAC   = COEF_W - 1;
    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = acc_width(DATA_W, COEF_W, NUM_TAPS);

    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(2 ** (FRAC - 1));
    localparam logic signed [ACC_W-1:0] MAX_OUT  = ACC_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_OUT  = ACC_W'(-(2 ** (DATA_W - 1)));

    // coefficient table unpacked from the parameter list
    logic signed [COEF_W-1:0] coef_tab [NUM_TAPS];
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_coef
        assign coef_tab[g] = COEF_LIST[g*COEF_W +: COEF_W];
    end

    logic signed [PRE_W-1:0]  pair_sum;
    logic signed [PROD_W-1:0] pair_x;
    logic signed [PROD_W-1:0] coef_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  ctr_term;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [ACC_W-1:0]  scaled;
    logic signed [DATA_W-1:0] clipped;

    always_comb begin
        pair_sum = PRE_W'(near_s) + PRE_W'(far_s);
        pair_x   = PROD_W'(pair_sum);
        coef_x   = PROD_W'(coef_tab[tap_idx]);
        prod     = pair_x * coef_x;
        ctr_term = ACC_W'(ctr_s) <<< (FRAC - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (ctl.load) begin
            acc <= ctr_term;
        end else if (ctl.mac) begin
            acc <= acc + ACC_W'(prod);
        end
    end

    always_comb begin
        rounded = acc + HALF_LSB;
        scaled  = rounded >>> FRAC;
        if (scaled > MAX_OUT) begin
            clipped = MAX_OUT[DATA_W-1:0];
        end else if (scaled < MIN_OUT) begin
            clipped = MIN_OUT[DATA_W-1:0];
        end else begin
            clipped = scaled[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.emit;
            if (ctl.emit) begin
                out_data <= clipped;
            end
        end
    end

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2
    import hb_pkg::*;
#(
    parameter int                         DATA_W    = 16,
    parameter int                         COEF_W    = 18,
    parameter int                         NUM_TAPS  = 4,
    parameter logic [NUM_TAPS*COEF_W-1:0] COEF_LIST =
        {18'h3FD71, 18'h00CCD, 18'h3DC29, 18'h0999A}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

    hb_ctl_t                  seq_ctl;
    logic [IDX_W-1:0]         seq_idx;
    logic                     seq_adj;
    logic                     seq_phase;
    hb_state_e                seq_state;
    logic signed [DATA_W-1:0] hist_near;
    logic signed [DATA_W-1:0] hist_far;
    logic signed [DATA_W-1:0] hist_ctr;
    logic signed [DATA_W-1:0] hist_newest;
    logic signed [DATA_W-1:0] mac_out;

    hb_sequencer #(
        .NUM_TAPS (NUM_TAPS),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .ctl      (seq_ctl),
        .tap_idx  (seq_idx),
        .adj      (seq_adj),
        .phase    (seq_phase),
        .state    (seq_state)
    );

    hb_history #(
        .DATA_W   (DATA_W),
        .NUM_TAPS (NUM_TAPS),
        .IDX_W    (IDX_W)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  ($signed(in_data)),
        .tap_idx  (seq_idx),
        .adj      (seq_adj),
        .near_s   (hist_near),
        .far_s    (hist_far),
        .ctr_s    (hist_ctr),
        .newest   (hist_newest)
    );

    hb_mac #(
        .DATA_W    (DATA_W),
        .COEF_W    (COEF_W),
        .NUM_TAPS  (NUM_TAPS),
        .IDX_W     (IDX_W),
        .COEF_LIST (COEF_LIST)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .ctl       (seq_ctl),
        .tap_idx   (seq_idx),
        .near_s    (hist_near),
        .far_s     (hist_far),
        .ctr_s     (hist_ctr),
        .out_valid (out_valid),
        .out_data  (mac_out)
    );

    assign out_data = mac_out;

endmodule

// File: rtl/hb_decim2_chk.sv
module hb_decim2_chk
    import hb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_TAPS = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     phase,
    input hb_state_e                state,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] newest
);

    localparam int          LAT   = NUM_TAPS + 2;
    localparam logic [15:0] LAT_M = 16'(LAT - 1);

    // cycles since the last triggering sample, saturating
    logic [15:0] since_trig;
    // accepted samples not yet paid for by an output
    logic [2:0]  pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_trig <= '1;
            pending    <= '0;
        end else begin
            if (in_valid && phase) begin
                since_trig <= '0;
            end else if (since_trig != 16'hFFFF) begin
                since_trig <= since_trig + 16'd1;
            end
            if (out_valid) begin
                pending <= pending - 3'd2 + {2'b00, in_valid};
            end else if (in_valid && pending != 3'd7) begin
                pending <= pending + 3'd1;
            end
        end
    end

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(since_trig) == LAT_M);

    assert_two_inputs_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> pending >= 3'd2);

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && phase) |-> (state == ST_IDLE || state == ST_OUT));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(newest));

endmodule

bind hb_decim2 hb_decim2_chk #(
    .DATA_W   (DATA_W),
    .NUM_TAPS (NUM_TAPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .phase     (seq_phase),
    .state     (seq_state),
    .out_valid (out_valid),
    .newest    (hist_newest)
);

// File: tb/sim_hb_decim2.sv
module sim_hb_decim2;

    localparam int DW     = 16;
    localparam int NT     = 4;
    localparam int LAT    = NT + 2;
    localparam int CENTER = 2 * NT - 1;
    localparam int WIN    = 4 * NT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    hb_decim2 u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2 clk = ~clk;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    string cur_req = "R8";
    int    mh [WIN];
    int    pushes = 0;
    int    exp_v [$];
    int    exp_c [$];
    int    out_seen = 0;
    int    last_out = 0;
    int    out_log [16];
    int    log_n = 0;
    logic [15:0] lf = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int coef(int k);
        case (k)
            0:       return 39322;
            1:       return -9175;
            2:       return 3277;
            default: return -655;
        endcase
    endfunction

    function automatic int model_out();
        longint a;
        a = longint'(mh[CENTER]) * 65536;
        for (int k = 0; k < NT; k++) begin
            a += longint'(coef(k)) * longint'(mh[2*NT-2-2*k] + mh[2*NT+2*k]);
        end
        a = (a + 65536) >>> 17;
        if (a > 32767) a = 32767;
        if (a < -32768) a = -32768;
        return int'(a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // output monitor: value against the model, timing against R2
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int got;
            got = int'($signed(out_data));
            out_seen++;
            last_out = got;
            if (log_n < 16) begin
                out_log[log_n] = got;
                log_n++;
            end
            if (exp_v.size() == 0) begin
                check(1'b0, "R1 unexpected output pulse", got, 0);
            end else begin
                int ev;
                int ec;
                ev = exp_v.pop_front();
                ec = exp_c.pop_front();
                check(got == ev, cur_req, got, ev);
                check(cyc == ec + LAT, "R2 output latency", cyc - ec, LAT);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < WIN; i++) mh[i] = 0;
        pushes = 0;
        exp_v.delete();
        exp_c.delete();
        log_n = 0;
        check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
        check(out_data == '0, "R8 out_data after reset", int'($signed(out_data)), 0);
    endtask

    task automatic push(input int v, input int gap);
        in_valid = 1'b1;
        in_data = v[DW-1:0];
        @(negedge clk);
        for (int i = WIN - 1; i > 0; i--) mh[i] = mh[i-1];
        mh[0] = v;
        pushes++;
        if (pushes % 2 == 0) begin
            exp_v.push_back(model_out());
            exp_c.push_back(cyc);
        end
        in_valid = 1'b0;
        in_data = 16'hA5A5 ^ cyc[15:0];
        for (int i = 1; i < gap; i++) begin
            @(negedge clk);
            in_data = 16'h5A3C ^ cyc[15:0];
        end
    endtask

    task automatic drain();
        repeat (LAT + 3) @(negedge clk);
        check(exp_v.size() == 0, "R1 missing output", exp_v.size(), 0);
    endtask

    function automatic int next_rand();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return int'($signed(lf));
    endfunction

    // R8: reset clears the input phase; R1 count
    task automatic test_reset_phase();
        int base;
        cur_req = "R8 value after reset";
        do_reset();
        push(100, 4);
        do_reset();
        base = out_seen;
        push(200, 4);
        push(300, 4);
        drain();
        check(out_seen - base == 1, "R8 phase restarts after reset", out_seen - base, 1);
    endtask

    // R3 zero-weight positions and R5 rounding via a center-only sample
    task automatic test_center(input int v, input int expect_last);
        int base;
        cur_req = "R3 zero-weight taps";
        do_reset();
        base = out_seen;
        for (int p = 1; p <= 16; p++) begin
            if (p == 16) cur_req = "R5 center rounding";
            push((p == 9) ? v : 0, 4);
        end
        drain();
        check(last_out == expect_last, "R5 half rounds upward", last_out, expect_last);
        check(out_seen - base == 8, "R1 outputs per 16 samples", out_seen - base, 8);
    endtask

    // R3/R4: impulse at an even position walks through all side taps
    task automatic test_impulse();
        int ref_v;
        cur_req = "R3 side tap weights";
        do_reset();
        for (int p = 1; p <= 16; p++) push((p == 2) ? 20000 : 0, 4);
        drain();
        for (int i = 0; i < 4; i++) begin
            check(out_log[i] == out_log[7-i], "R4 mirrored taps equal", out_log[i], out_log[7-i]);
        end
        ref_v = int'((longint'(20000) * 39322 + 65536) >>> 17);
        check(out_log[3] == ref_v, "R3 nearest tap weight", out_log[3], ref_v);
    endtask

    function automatic int sat_val(int j, bit pos);
        int k;
        bit hi;
        if (j == CENTER) return pos ? 32767 : -32768;
        if (j % 2 == 1 || j >= WIN - 1) return 0;
        k = (j < CENTER) ? (2*NT - 2 - j) / 2 : (j - 2*NT) / 2;
        hi = ((coef(k) > 0) == pos);
        return hi ? 32767 : -32768;
    endfunction

    // R6: push the sum past either rail
    task automatic test_saturate(input bit pos);
        int rail;
        cur_req = "R6 saturation";
        rail = pos ? 32767 : -32768;
        do_reset();
        for (int p = 1; p <= 16; p++) push(sat_val(16 - p, pos), 4);
        drain();
        check(last_out == rail, "R6 clipped to rail", last_out, rail);
    endtask

    // R7: densest allowed input rate, samples arrive mid-computation
    task automatic test_tight();
        int base;
        cur_req = "R7 mid-computation input";
        do_reset();
        base = out_seen;
        for (int i = 0; i < 40; i++) push(next_rand(), LAT / 2);
        drain();
        check(out_seen - base == 20, "R1 outputs per 40 samples", out_seen - base, 20);
    endtask

    // R9: data moving with in_valid low changes nothing
    task automatic test_idle_data();
        int base;
        cur_req = "R9 idle data ignored";
        do_reset();
        for (int i = 0; i < 6; i++) push(next_rand(), 7);
        drain();
        base = out_seen;
        for (int i = 0; i < 20; i++) begin
            in_data = lf ^ 16'(i * 4099);
            @(negedge clk);
        end
        check(out_seen == base, "R9 no output while idle", out_seen - base, 0);
        for (int i = 0; i < 4; i++) push(next_rand(), 7);
        drain();
    endtask

    initial begin
        for (int i = 0; i < WIN; i++) mh[i] = 0;
        @(negedge clk);
        test_reset_phase();
        test_center(3, 2);
        test_center(-3, -1);
        test_impulse();
        test_saturate(1'b1);
        test_saturate(1'b0);
        test_tight();
        test_idle_data();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule